// File: doc/BRIEF.md
# Two-Address Indirect Register Port for a Dual-Channel Serial Controller

This block is the host-side register front end of a two-channel serial controller. Each channel shows the host two locations: a control location and a data location. The host reaches most registers in two steps. It first writes a byte to the control location while the channel's pointer is zero. That byte carries a register number, a command field and a reset field. The next control access, read or write, lands on the numbered register, and the pointer then falls back to zero. Reaching the upper eight registers takes the explicit "point high" command in the same byte. Command and reset fields become single-cycle strobes for the serial engines.

The block holds the write-register storage: one copy per channel for most registers, and one copy shared by both channels for the interrupt vector and the master interrupt control register. The master interrupt control register also carries a reset field that clears one channel or the whole port. Read accesses select among status bytes supplied by the neighbouring logic, read-back of some write registers, and an interrupt-pending summary. Data-location writes and reads go straight to the transmit and receive paths and do not touch the pointer.

Top module: `sio_regport`

## Requirements
- R1: After reset, both pointers are 0, every write register reads 0 on `wreg_o`, and every strobe output and `host_rdata_o` are 0.
- R2: A control write at pointer 0 loads the pointer from byte bits 2:0. The next control access on that channel reaches the named register, and the pointer then returns to 0, so the following control read returns status byte 0.
- R3: Registers 8 to 15 are reachable only when the command field (bits 5:3) equals 1 (byte 0x08). That command sets pointer bit 3. Without it, a byte with bits 2:0 = 4 selects register 4.
- R4: A control write at pointer 0 with command field 2..7 raises `cmd_stb_o[ch*8+code]` for exactly the cycle after the write. Command 0 (null) and 1 (point high) raise no strobe.
- R5: The reset field (bits 7:6) values 1 (receive CRC), 2 (transmit CRC) and 3 (transmit underrun/end-of-message) raise `rst_stb_o[ch*4+code]` for one cycle after the write. It may fire in the same cycle as a command strobe from the same byte.
- R6: Registers 2 and 9 are one storage shared by both channels and appear in both channels' slots of `wreg_o`, where register r of channel ch is `wreg_o[(ch*16+r)*8 +: 8]`. All other registers are separate per channel.
- R7: Writing register 9 with bits 7:6 = 3 clears all write registers and both pointers and pulses `full_rst_o` and both `chan_rst_o` bits. Bits 7:6 = 2 clears channel A's own registers and pulses `chan_rst_o[0]`. Bits 7:6 = 1 does the same for channel B and `chan_rst_o[1]`. Bits 7:6 are never stored.
- R8: Read register 15 returns write register 15 with bits 2 and 0 forced to 0.
- R9: Read register 3 on channel A returns {2'b00, `ipend_i[5:0]`}, where bits 5/4/3 are A receive/transmit/status and bits 2/1/0 are B receive/transmit/status. On channel B it returns 0.
- R10: Read registers 0, 1 and 10 return the channel's `stat0_i`, `stat1_i` and `stat10_i`. Registers 2, 12 and 13 return the stored write register. All others return 0. Read data appears on `host_rdata_o` the cycle after the access and holds until the next read.
- R11: A data-location write pulses `txd_stb_o[ch]` for one cycle with the byte on `txd_o`. A data-location read returns `rxd_i` of that channel. Neither changes the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel_i | input | 1 | Host access valid this cycle |
| host_wr_i | input | 1 | Access is a write |
| host_rd_i | input | 1 | Access is a read |
| host_ch_i | input | 1 | Channel: 0 = A, 1 = B |
| host_data_port_i | input | 1 | 0 = control location, 1 = data location |
| host_wdata_i | input | 8 | Write byte |
| host_rdata_o | output | 8 | Read byte, registered |
| stat0_i | input | 16 | Status byte 0 per channel (channel ch at bits ch*8+7:ch*8) |
| stat1_i | input | 16 | Status byte 1 per channel |
| stat10_i | input | 16 | Status byte 10 per channel |
| ipend_i | input | 6 | Interrupt-pending flags of both channels |
| rxd_i | input | 16 | Received byte per channel |
| cmd_stb_o | output | 16 | Command strobes, index ch*8+code |
| rst_stb_o | output | 8 | Reset-field strobes, index ch*4+code |
| chan_rst_o | output | 2 | Channel reset pulse per channel |
| full_rst_o | output | 1 | Whole-port reset pulse |
| txd_stb_o | output | 2 | Transmit byte strobe per channel |
| txd_o | output | 8 | Transmit byte |
| wreg_o | output | 256 | All write registers, both channels |

## Verification
The pulse-width properties assume that the host never places two accesses in adjacent cycles and never raises read and write together. The bench tasks drive each access for one cycle and then release the bus, so there is always an idle cycle between accesses. Status and receive inputs are held steady across a read, so the registered read value is fixed by the cycle of the access.

// File: rtl/sio_regport_pkg.sv
package sio_regport_pkg;

   localparam int unsigned BYTE_W = 8;

   // command field, byte bits 5:3
   typedef enum logic [2:0] {
      CMD_NULL     = 3'd0,
      CMD_PTR_HIGH = 3'd1,
      CMD_CLR_EXT  = 3'd2,
      CMD_ABORT    = 3'd3,
      CMD_RX_NEXT  = 3'd4,
      CMD_CLR_TXI  = 3'd5,
      CMD_CLR_ERR  = 3'd6,
      CMD_CLR_IUS  = 3'd7
   } cmd_e;

   // reset field, byte bits 7:6
   typedef enum logic [1:0] {
      RST_NONE    = 2'd0,
      RST_RX_CRC  = 2'd1,
      RST_TX_CRC  = 2'd2,
      RST_TX_UEOM = 2'd3
   } rst_e;

   // reset field of the master interrupt control register
   typedef enum logic [1:0] {
      MIC_NONE  = 2'd0,
      MIC_CHB   = 2'd1,
      MIC_CHA   = 2'd2,
      MIC_ALL   = 2'd3
   } mic_rst_e;

   localparam int unsigned REG_VEC   = 2;
   localparam int unsigned REG_MIC   = 9;
   localparam int unsigned RD_STAT0  = 0;
   localparam int unsigned RD_STAT1  = 1;
   localparam int unsigned RD_IPEND  = 3;
   localparam int unsigned RD_STAT10 = 10;
   localparam int unsigned RD_TC_LO  = 12;
   localparam int unsigned RD_TC_HI  = 13;
   localparam int unsigned RD_EXTIE  = 15;
   localparam logic [BYTE_W-1:0] EXTIE_MASK = 8'hFA;

   function automatic logic is_shared(input int unsigned idx);
      return (idx == REG_VEC) || (idx == REG_MIC);
   endfunction

endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
   import sio_regport_pkg::*;
#(
   parameter int unsigned SEL_W = 3
) (
   input  logic [BYTE_W-1:0] byte_i,
   output logic [SEL_W-1:0]  sel_o,
   output cmd_e              cmd_o,
   output rst_e              rst_o,
   output logic              high_o,
   output logic              cmd_fire_o,
   output logic              rst_fire_o
);

   if (SEL_W != 3) begin : g_chk
      $error("sio_cmd_decode: selector field must be 3 bits");
   end

   always_comb begin
      sel_o      = byte_i[SEL_W-1:0];
      cmd_o      = cmd_e'(byte_i[5:3]);
      rst_o      = rst_e'(byte_i[7:6]);
      high_o     = (cmd_o == CMD_PTR_HIGH);
      cmd_fire_o = (cmd_o != CMD_NULL) && (cmd_o != CMD_PTR_HIGH);
      rst_fire_o = (rst_o != RST_NONE);
   end

endmodule

// File: rtl/sio_ptr_track.sv
module sio_ptr_track #(
   parameter int unsigned NUM_REGS = 16,
   localparam int unsigned PTR_W = $clog2(NUM_REGS),
   localparam int unsigned SEL_W = PTR_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_i,
   input  logic             we_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             high_i,
   output logic [PTR_W-1:0] ptr_o
);

   if (NUM_REGS != 16) begin : g_chk
      $error("sio_ptr_track: register space must hold 16 entries");
   end

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_d;
   logic             at_zero;

   assign at_zero = (ptr_q == '0);

   always_comb begin
      ptr_d = ptr_q;
      if (clr_i) begin
         ptr_d = '0;
      end else if (acc_i) begin
         if (at_zero && we_i) begin
            ptr_d = {high_i, sel_i};
         end else if (!at_zero) begin
            ptr_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else begin
         ptr_q <= ptr_d;
      end
   end

   assign ptr_o = ptr_q;

   // R2: one access to a selected register sends the pointer home
   p_ptr_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i && !at_zero) |=> (ptr_q == '0));

   // R3: upper bank entered only through the point-high command
   p_high_only_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ptr_q[PTR_W-1]) |-> $past(acc_i && we_i && high_i));

endmodule

// File: rtl/sio_wreg_file.sv
module sio_wreg_file
   import sio_regport_pkg::*;
#(
   parameter int unsigned NCH      = 2,
   parameter int unsigned NUM_REGS = 16,
   localparam int unsigned PTR_W = $clog2(NUM_REGS),
   localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned TOT_W = NCH * NUM_REGS * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_vld_i,
   input  logic [CH_W-1:0]   wr_ch_i,
   input  logic [PTR_W-1:0]  wr_idx_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   output logic              full_now_o,
   output logic [NCH-1:0]    chan_now_o,
   output logic [TOT_W-1:0]  wreg_o
);

   if (NCH != 2) begin : g_chk
      $error("sio_wreg_file: the shared register scheme needs two channels");
   end

   logic              mic_hit;
   mic_rst_e          mic_field;
   logic [BYTE_W-1:0] vec_q;
   logic [BYTE_W-1:0] mic_q;

   assign mic_hit    = wr_vld_i && (wr_idx_i == PTR_W'(REG_MIC));
   assign mic_field  = mic_rst_e'(wr_data_i[7:6]);
   assign full_now_o = mic_hit && (mic_field == MIC_ALL);

   always_comb begin
      chan_now_o = '0;
      if (mic_hit) begin
         chan_now_o[0] = (mic_field == MIC_CHA) || (mic_field == MIC_ALL);
         chan_now_o[1] = (mic_field == MIC_CHB) || (mic_field == MIC_ALL);
      end
   end

   // storage common to both channels
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q <= '0;
         mic_q <= '0;
      end else if (full_now_o) begin
         vec_q <= '0;
         mic_q <= '0;
      end else if (wr_vld_i && (wr_idx_i == PTR_W'(REG_VEC))) begin
         vec_q <= wr_data_i;
      end else if (mic_hit) begin
         mic_q <= {2'b00, wr_data_i[5:0]};
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;
      logic                            own_wr;

      assign own_wr = wr_vld_i && (wr_ch_i == CH_W'(c))
                      && !is_shared(int'(wr_idx_i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q <= '0;
         end else if (chan_now_o[c]) begin
            regs_q <= '0;
         end else if (own_wr) begin
            regs_q[wr_idx_i] <= wr_data_i;
         end
      end

      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         localparam int unsigned BASE = (c * NUM_REGS + r) * BYTE_W;
         if (r == REG_VEC) begin : g_vec
            assign wreg_o[BASE +: BYTE_W] = vec_q;
         end else if (r == REG_MIC) begin : g_mic
            assign wreg_o[BASE +: BYTE_W] = mic_q;
         end else begin : g_own
            assign wreg_o[BASE +: BYTE_W] = regs_q[r];
         end
      end
   end

   // R6: shared vector changes only on a write aimed at it or a full reset
   p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_vld_i && (wr_idx_i == PTR_W'(REG_VEC))) && !full_now_o |=> $stable(vec_q));

   // R7: the reset field never lands in storage
   p_mic_top_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mic_hit |=> (mic_q[7:6] == 2'b00));

endmodule

// File: rtl/sio_read_mux.sv
module sio_read_mux
   import sio_regport_pkg::*;
#(
   parameter int unsigned NCH      = 2,
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned IPEND_W  = 6,
   localparam int unsigned PTR_W = $clog2(NUM_REGS),
   localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned TOT_W = NCH * NUM_REGS * BYTE_W
) (
   input  logic [CH_W-1:0]       ch_i,
   input  logic [PTR_W-1:0]      idx_i,
   input  logic [NCH*BYTE_W-1:0] stat0_i,
   input  logic [NCH*BYTE_W-1:0] stat1_i,
   input  logic [NCH*BYTE_W-1:0] stat10_i,
   input  logic [IPEND_W-1:0]    ipend_i,
   input  logic [TOT_W-1:0]      wreg_i,
   output logic [BYTE_W-1:0]     rd_o
);

   if (IPEND_W + 2 != BYTE_W) begin : g_chk
      $error("sio_read_mux: pending summary must leave two top bits");
   end

   logic [BYTE_W-1:0] wsel;
   int unsigned       chn;

   always_comb begin
      chn  = int'(ch_i);
      wsel = wreg_i[(chn * NUM_REGS + int'(idx_i)) * BYTE_W +: BYTE_W];
      rd_o = '0;
      case (int'(idx_i))
         RD_STAT0:  rd_o = stat0_i[chn * BYTE_W +: BYTE_W];
         RD_STAT1:  rd_o = stat1_i[chn * BYTE_W +: BYTE_W];
         REG_VEC:   rd_o = wsel;
         RD_IPEND:  rd_o = (chn == 0) ? {2'b00, ipend_i} : '0;
         RD_STAT10: rd_o = stat10_i[chn * BYTE_W +: BYTE_W];
         RD_TC_LO:  rd_o = wsel;
         RD_TC_HI:  rd_o = wsel;
         RD_EXTIE:  rd_o = wsel & EXTIE_MASK;
         default:   rd_o = '0;
      endcase
   end

endmodule

// File: rtl/sio_regport.sv
module sio_regport
   import sio_regport_pkg::*;
#(
   parameter int unsigned NCH      = 2,
   parameter int unsigned NUM_REGS = 16,
   parameter int unsigned IPEND_W  = 6,
   localparam int unsigned PTR_W  = $clog2(NUM_REGS),
   localparam int unsigned SEL_W  = PTR_W - 1,
   localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int unsigned NCMD   = 1 << 3,
   localparam int unsigned NRST   = 1 << 2,
   localparam int unsigned TOT_W  = NCH * NUM_REGS * BYTE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_sel_i,
   input  logic                  host_wr_i,
   input  logic                  host_rd_i,
   input  logic [CH_W-1:0]       host_ch_i,
   input  logic                  host_data_port_i,
   input  logic [BYTE_W-1:0]     host_wdata_i,
   output logic [BYTE_W-1:0]     host_rdata_o,
   input  logic [NCH*BYTE_W-1:0] stat0_i,
   input  logic [NCH*BYTE_W-1:0] stat1_i,
   input  logic [NCH*BYTE_W-1:0] stat10_i,
   input  logic [IPEND_W-1:0]    ipend_i,
   input  logic [NCH*BYTE_W-1:0] rxd_i,
   output logic [NCH*NCMD-1:0]   cmd_stb_o,
   output logic [NCH*NRST-1:0]   rst_stb_o,
   output logic [NCH-1:0]        chan_rst_o,
   output logic                  full_rst_o,
   output logic [NCH-1:0]        txd_stb_o,
   output logic [BYTE_W-1:0]     txd_o,
   output logic [TOT_W-1:0]      wreg_o
);

   if (NCH != 2) begin : g_chk_ch
      $error("sio_regport: exactly two channels are supported");
   end
   if (NUM_REGS != 16) begin : g_chk_regs
      $error("sio_regport: sixteen registers per channel are required");
   end

   // ---------------- access qualification ----------------
   logic ctrl_wr, ctrl_rd, data_wr, data_rd;
   assign ctrl_wr = host_sel_i && !host_data_port_i && host_wr_i;
   assign ctrl_rd = host_sel_i && !host_data_port_i && host_rd_i;
   assign data_wr = host_sel_i &&  host_data_port_i && host_wr_i;
   assign data_rd = host_sel_i &&  host_data_port_i && host_rd_i;

   // ---------------- byte decode ----------------
   logic [SEL_W-1:0] dec_sel;
   cmd_e             dec_cmd;
   rst_e             dec_rst;
   logic             dec_high, dec_cmd_fire, dec_rst_fire;

   sio_cmd_decode #(.SEL_W(SEL_W)) u_dec (
      .byte_i     (host_wdata_i),
      .sel_o      (dec_sel),
      .cmd_o      (dec_cmd),
      .rst_o      (dec_rst),
      .high_o     (dec_high),
      .cmd_fire_o (dec_cmd_fire),
      .rst_fire_o (dec_rst_fire)
   );

   // ---------------- per-channel pointers ----------------
   logic [NCH-1:0][PTR_W-1:0] ptr_v;
   logic [NCH-1:0]            chan_now;
   logic                      full_now;
   logic [PTR_W-1:0]          cur_ptr;

   for (genvar c = 0; c < NCH; c++) begin : g_ptr
      logic acc;
      assign acc = (ctrl_wr || ctrl_rd) && (host_ch_i == CH_W'(c));
      sio_ptr_track #(.NUM_REGS(NUM_REGS)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .acc_i  (acc),
         .we_i   (ctrl_wr),
         .clr_i  (chan_now[c]),
         .sel_i  (dec_sel),
         .high_i (dec_high),
         .ptr_o  (ptr_v[c])
      );
   end

   assign cur_ptr = ptr_v[host_ch_i];

   logic cmd_hit, reg_wr, reg_rd;
   assign cmd_hit = ctrl_wr && (cur_ptr == '0);
   assign reg_wr  = ctrl_wr && (cur_ptr != '0);
   assign reg_rd  = ctrl_rd;

   // ---------------- write storage ----------------
   sio_wreg_file #(.NCH(NCH), .NUM_REGS(NUM_REGS)) u_wregs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_vld_i   (reg_wr),
      .wr_ch_i    (host_ch_i),
      .wr_idx_i   (cur_ptr),
      .wr_data_i  (host_wdata_i),
      .full_now_o (full_now),
      .chan_now_o (chan_now),
      .wreg_o     (wreg_o)
   );

   // ---------------- read selection ----------------
   logic [BYTE_W-1:0] rd_sel;

   sio_read_mux #(.NCH(NCH), .NUM_REGS(NUM_REGS), .IPEND_W(IPEND_W)) u_rmux (
      .ch_i     (host_ch_i),
      .idx_i    (cur_ptr),
      .stat0_i  (stat0_i),
      .stat1_i  (stat1_i),
      .stat10_i (stat10_i),
      .ipend_i  (ipend_i),
      .wreg_i   (wreg_o),
      .rd_o     (rd_sel)
   );

   // ---------------- registered strobes and read data ----------------
   logic [NCH*NCMD-1:0] cmd_stb_q;
   logic [NCH*NRST-1:0] rst_stb_q;
   logic [NCH-1:0]      chan_rst_q, txd_stb_q;
   logic                full_rst_q;
   logic [BYTE_W-1:0]   txd_q, rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_stb_q  <= '0;
         rst_stb_q  <= '0;
         chan_rst_q <= '0;
         full_rst_q <= 1'b0;
         txd_stb_q  <= '0;
         txd_q      <= '0;
         rdata_q    <= '0;
      end else begin
         cmd_stb_q  <= '0;
         rst_stb_q  <= '0;
         txd_stb_q  <= '0;
         chan_rst_q <= chan_now;
         full_rst_q <= full_now;
         if (cmd_hit && dec_cmd_fire) begin
            cmd_stb_q[int'(host_ch_i) * NCMD + int'(dec_cmd)] <= 1'b1;
         end
         if (cmd_hit && dec_rst_fire) begin
            rst_stb_q[int'(host_ch_i) * NRST + int'(dec_rst)] <= 1'b1;
         end
         if (data_wr) begin
            txd_stb_q[host_ch_i] <= 1'b1;
            txd_q                <= host_wdata_i;
         end
         if (reg_rd) begin
            rdata_q <= rd_sel;
         end else if (data_rd) begin
            rdata_q <= rxd_i[int'(host_ch_i) * BYTE_W +: BYTE_W];
         end
      end
   end

   assign cmd_stb_o    = cmd_stb_q;
   assign rst_stb_o    = rst_stb_q;
   assign chan_rst_o   = chan_rst_q;
   assign full_rst_o   = full_rst_q;
   assign txd_stb_o    = txd_stb_q;
   assign txd_o        = txd_q;
   assign host_rdata_o = rdata_q;

   // R4: every command strobe lasts a single cycle
   p_cmd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o != '0) |=> ((cmd_stb_o & $past(cmd_stb_o)) == '0));

   // R4: null and point-high never strobe
   p_cmd_quiet_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb_o[0] == 1'b0) && (cmd_stb_o[1] == 1'b0)
      && (cmd_stb_o[NCMD] == 1'b0) && (cmd_stb_o[NCMD+1] == 1'b0));

   // R5: at most one reset-field strobe per channel, single cycle
   p_rst_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rst_stb_o[NRST-1:0]) && $onehot0(rst_stb_o[2*NRST-1:NRST])
      && ((rst_stb_o & $past(rst_stb_o)) == '0));

   // R7: a full reset leaves both pointers at zero
   p_full_ptrs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      full_rst_o |-> (ptr_v == '0));

   // R8: readback of register 15 masks bits 2 and 0
   p_extie_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd && (cur_ptr == PTR_W'(RD_EXTIE))) |=>
      (host_rdata_o[2] == 1'b0) && (host_rdata_o[0] == 1'b0));

   // R9: channel B has no pending summary
   p_ipend_b_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd && (host_ch_i == CH_W'(1)) && (cur_ptr == PTR_W'(RD_IPEND)))
      |=> (host_rdata_o == '0));

   // R11: data-location traffic leaves the pointers alone
   p_data_keeps_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel_i && host_data_port_i && !chan_now[0] && !chan_now[1])
      |=> $stable(ptr_v));

endmodule

// File: tb/sio_regport_tb.sv
module sio_regport_tb;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_sel_i = 1'b0, host_wr_i = 1'b0, host_rd_i = 1'b0;
   logic [0:0]   host_ch_i = '0;
   logic         host_data_port_i = 1'b0;
   logic [7:0]   host_wdata_i = '0;
   logic [7:0]   host_rdata_o;
   logic [15:0]  stat0_i, stat1_i, stat10_i, rxd_i;
   logic [5:0]   ipend_i;
   logic [15:0]  cmd_stb_o;
   logic [7:0]   rst_stb_o;
   logic [1:0]   chan_rst_o, txd_stb_o;
   logic         full_rst_o;
   logic [7:0]   txd_o;
   logic [255:0] wreg_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sio_regport u_dut (
      .clk(clk), .rst_n(rst_n), .host_sel_i(host_sel_i), .host_wr_i(host_wr_i),
      .host_rd_i(host_rd_i), .host_ch_i(host_ch_i), .host_data_port_i(host_data_port_i),
      .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o), .stat0_i(stat0_i),
      .stat1_i(stat1_i), .stat10_i(stat10_i), .ipend_i(ipend_i), .rxd_i(rxd_i),
      .cmd_stb_o(cmd_stb_o), .rst_stb_o(rst_stb_o), .chan_rst_o(chan_rst_o),
      .full_rst_o(full_rst_o), .txd_stb_o(txd_stb_o), .txd_o(txd_o), .wreg_o(wreg_o)
   );

   function automatic logic [7:0] wv(input int ch, input int r);
      return wreg_o[(ch*16 + r)*8 +: 8];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic access(input int ch, input bit data, input bit wr, input logic [7:0] d);
      @(negedge clk);
      host_sel_i = 1'b1; host_ch_i = 1'(ch); host_data_port_i = data;
      host_wr_i = wr; host_rd_i = !wr; host_wdata_i = d;
      @(negedge clk);
      host_sel_i = 1'b0; host_wr_i = 1'b0; host_rd_i = 1'b0;
   endtask

   task automatic cwr(input int ch, input logic [7:0] d);
      access(ch, 1'b0, 1'b1, d);
   endtask

   task automatic crd(input int ch, output logic [7:0] q);
      access(ch, 1'b0, 1'b0, 8'h00);
      q = host_rdata_o;
   endtask

   task automatic set_reg(input int ch, input int r, input logic [7:0] d);
      cwr(ch, {2'b00, (r >= 8) ? 3'd1 : 3'd0, 3'(r)});
      cwr(ch, d);
   endtask

   task automatic t_reset;
      chk("R1 wreg", 32'(wreg_o != '0), 0);
      chk("R1 strobes", {cmd_stb_o, rst_stb_o, chan_rst_o, txd_stb_o}, 0);
      chk("R1 rdata", host_rdata_o, 0);
   endtask

   task automatic t_pointer;
      logic [7:0] q;
      set_reg(0, 5, 8'h5A);
      chk("R2 reg5 written", wv(0, 5), 8'h5A);
      cwr(0, 8'h01);
      crd(0, q);
      chk("R2 read of reg1", q, 8'h11);
      crd(0, q);
      chk("R2 pointer home, status0", q, 8'h3C);
   endtask

   task automatic t_point_high;
      logic [7:0] q;
      set_reg(0, 12, 8'h77);
      chk("R3 reg12 written", wv(0, 12), 8'h77);
      chk("R3 reg4 untouched", wv(0, 4), 8'h00);
      cwr(0, 8'h04);
      cwr(0, 8'h66);
      chk("R3 no high gives reg4", wv(0, 4), 8'h66);
      chk("R3 reg12 kept", wv(0, 12), 8'h77);
      cwr(0, 8'h0C);
      crd(0, q);
      chk("R10 readback reg12", q, 8'h77);
   endtask

   task automatic t_cmds;
      logic [7:0] q;
      for (int code = 2; code < 8; code++) begin
         cwr(1, {2'b00, 3'(code), 3'b000});
         chk("R4 command strobe", cmd_stb_o, 32'(16'h1 << (8 + code)));
         @(negedge clk);
         chk("R4 strobe one cycle", cmd_stb_o, 0);
      end
      cwr(1, 8'h00);
      chk("R4 null quiet", cmd_stb_o, 0);
      cwr(1, 8'h08);
      chk("R4 point-high quiet", cmd_stb_o, 0);
      crd(1, q);
      chk("R10 unlisted reg8 reads 0", q, 0);
   endtask

   task automatic t_resets;
      for (int code = 1; code < 4; code++) begin
         cwr(0, {2'(code), 6'b000000});
         chk("R5 reset strobe", rst_stb_o, 32'(8'h1 << code));
         @(negedge clk);
         chk("R5 reset one cycle", rst_stb_o, 0);
      end
      cwr(1, 8'hE8);
      chk("R5 combined reset", rst_stb_o, 32'(8'h1 << 7));
      chk("R5 combined command", cmd_stb_o, 32'(16'h1 << 13));
   endtask

   task automatic t_shared;
      logic [7:0] q;
      set_reg(0, 2, 8'h9C);
      chk("R6 vec in A", wv(0, 2), 8'h9C);
      chk("R6 vec in B", wv(1, 2), 8'h9C);
      cwr(1, 8'h02);
      crd(1, q);
      chk("R10 vec read via B", q, 8'h9C);
      set_reg(1, 5, 8'h33);
      chk("R6 B reg5 own", wv(1, 5), 8'h33);
      chk("R6 A reg5 separate", wv(0, 5), 8'h5A);
   endtask

   task automatic t_mic;
      logic [7:0] q;
      set_reg(0, 3, 8'h11);
      set_reg(1, 3, 8'h22);
      cwr(0, 8'h08 | 8'h01);
      cwr(0, 8'h88);
      chk("R7 chan A pulse", {full_rst_o, chan_rst_o}, 3'b001);
      chk("R7 A cleared", wv(0, 3), 0);
      chk("R7 B kept", wv(1, 3), 8'h22);
      chk("R7 field not stored", wv(1, 9), 8'h08);
      cwr(1, 8'h09);
      cwr(1, 8'h48);
      chk("R7 chan B pulse", {full_rst_o, chan_rst_o}, 3'b010);
      chk("R7 B cleared", wv(1, 3), 0);
      set_reg(1, 3, 8'h44);
      cwr(1, 8'h03);
      cwr(0, 8'h09);
      cwr(0, 8'hC0);
      chk("R7 full pulse", {full_rst_o, chan_rst_o}, 3'b111);
      chk("R7 all wregs clear", 32'(wreg_o != '0), 0);
      @(negedge clk);
      chk("R7 pulse ends", {full_rst_o, chan_rst_o}, 0);
      crd(1, q);
      chk("R7 B pointer cleared", q, 8'hB0);
   endtask

   task automatic t_reads;
      logic [7:0] q;
      set_reg(0, 15, 8'hFF);
      chk("R8 wreg15 stored", wv(0, 15), 8'hFF);
      cwr(0, 8'h0F);
      crd(0, q);
      chk("R8 rr15 masked", q, 8'hFA);
      cwr(0, 8'h03);
      crd(0, q);
      chk("R9 A pending", q, 8'h2B);
      cwr(1, 8'h03);
      crd(1, q);
      chk("R9 B reads zero", q, 0);
      cwr(1, 8'h0A);
      crd(1, q);
      chk("R10 status10 B", q, 8'hD4);
      @(negedge clk);
      chk("R10 read data holds", host_rdata_o, 8'hD4);
   endtask

   task automatic t_data;
      logic [7:0] q;
      cwr(0, 8'h06);
      access(0, 1'b1, 1'b1, 8'hA5);
      chk("R11 tx strobe", {txd_stb_o, txd_o}, {2'b01, 8'hA5});
      @(negedge clk);
      chk("R11 tx strobe ends", txd_stb_o, 0);
      access(1, 1'b1, 1'b0, 8'h00);
      chk("R11 rx read", host_rdata_o, 8'h5E);
      cwr(0, 8'h44);
      chk("R11 pointer survived", wv(0, 6), 8'h44);
   endtask

   initial begin
      stat0_i = 16'hB03C; stat1_i = 16'h2211; stat10_i = 16'hD4C1;
      ipend_i = 6'h2B; rxd_i = 16'h5E7A;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_pointer;
      t_point_high;
      t_cmds;
      t_resets;
      t_shared;
      t_mic;
      t_reads;
      t_data;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule